// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block walks a ring of transmit buffer descriptors held in system memory, gathers the buffers they point to into frames and streams those frames out one byte at a time. A walk starts when the host pulses the activate input while the controller enable is high. The engine then works through the ring. For each descriptor it reads the header and the buffer pointer and fetches the buffer bytes. It writes the header back with ownership handed back to software and moves on, either to the next slot or back to the ring base. The walk ends at the first descriptor that software has not marked ready, or when the runaway guard limit is reached.

Memory is reached through a simple request/acknowledge port with 32-bit words and byte addresses. Frame data leaves on an AXI4-Stream style byte channel with `tlast`. Three single-cycle event pulses report a finished buffer, a finished frame and a frame that had to be truncated. Those pulses feed an event register that lives outside this block.

Top module: `txring_dma`

## Requirements
- R1: After reset `busy`, `mem_req`, `tx_tvalid` and all three event pulses are low.
- R2: A walk starts only on `kick` while `enable` is high and the engine is idle. `kick` while disabled issues no memory request and leaves `busy` low. `kick` during a walk has no effect on that walk.
- R3: A descriptor is two words at a descriptor address D. Word D holds the length in bits 15:0 and the flags in bits 31:16, with Ready at flag bit 15 (word bit 31), Wrap at flag bit 13 (word bit 29) and Last at flag bit 11 (word bit 27). Word D+4 holds the buffer byte address. The walk reads word D first and stops, without reading D+4, when Ready is clear.
- R4: Buffer bytes are fetched in ascending address order. The byte at address A is read from the word at A with bits 1:0 cleared, lane A[1:0] little-endian (lane 0 = bits 7:0), and is presented on `tx_tdata`.
- R5: `tx_tlast` is high exactly on the final byte taken from a descriptor whose Last flag is set.
- R6: While `tx_tvalid` is high and `tx_tready` is low, `tx_tvalid`, `tx_tdata` and `tx_tlast` hold. No memory request is made while a byte waits.
- R7: Each processed descriptor is written back to word D with Ready cleared and every other bit unchanged. One cycle after that write is acknowledged, `ev_txbuf` pulses, and `ev_txframe` pulses along with it when Last is set.
- R8: After a descriptor, the next one is at the ring base if its Wrap flag is set, and at D+8 otherwise.
- R9: When the bytes already taken in the current frame plus a descriptor's length exceed `MAX_FRAME`, only `MAX_FRAME` minus the bytes taken is used and `ev_babble` pulses. The byte count restarts after each Last descriptor and at every activation.
- R10: At most `MAX_DESC` descriptors are processed per activation. After the last one is written back the walk ends without reading another header.
- R11: A ring base write clears the low `ALIGN_LOG2` address bits. The current descriptor pointer reloads from the base on a base write or while `enable` is low, whenever the engine is idle.
- R12: A memory request holds its address, direction and write data until the cycle in which `mem_ack` is high.
- R13: `busy` is high from the cycle after an accepted `kick` until the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable level |
| base_we | input | 1 | Ring base write strobe |
| base_wdata | input | ADDR_W | Ring base write value |
| kick | input | 1 | Activate pulse |
| busy | output | 1 | Activate readback, high during a walk |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tdata | output | 8 | Stream byte |
| tx_tlast | output | 1 | Final byte of a frame |
| ev_txbuf | output | 1 | Buffer done pulse |
| ev_txframe | output | 1 | Frame done pulse |
| ev_babble | output | 1 | Frame truncated pulse |

## Verification
The bench builds the engine with `MAX_FRAME` = 40, `MAX_DESC` = 6 and `ALIGN_LOG2` = 3. With these values a few short descriptors can push a frame past the truncation limit, including a Last descriptor that contributes nothing. An eight-slot ring runs into the runaway guard and is then finished by a second activation. An odd base value exposes the 8-byte alignment. Memory latency and sink back-pressure vary at random, so every fetch state and the held stream output are exercised while waiting.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_HEAD, S_PTR, S_FETCH, S_SEND, S_WBACK
  } walk_state_t;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
  } desc_head_t;

  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;
  localparam logic [15:0] READY_MASK = 16'h8000;
  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr import txr_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              busy,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              step,
  input  logic              wrap,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] cur
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_LOG2) - 1);
  logic [ADDR_W-1:0] aligned_wdata;
  assign aligned_wdata = base_wdata & ~LOW_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      cur  <= '0;
    end else begin
      if (base_we) base <= aligned_wdata;
      if (step)                 cur <= wrap ? base : cur + ADDR_W'(DESC_BYTES);
      else if (!busy && base_we) cur <= aligned_wdata;
      else if (!busy && !enable) cur <= base;
    end
  end

  a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable && !step) |=> (cur == base));
  a_r8_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wrap && !base_we) |=> (cur == base));
endmodule

// File: rtl/txr_frame_len.sv
module txr_frame_len #(
  parameter int MAX_FRAME = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        load,
  input  logic        frame_end,
  input  logic [15:0] desc_len,
  output logic [15:0] take_len,
  output logic        over
);
  localparam int ACC_W = $clog2(MAX_FRAME + 1);
  localparam int SUM_W = ((ACC_W > 16) ? ACC_W : 16) + 1;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'(MAX_FRAME);

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum, room;

  assign sum      = SUM_W'(acc) + SUM_W'(desc_len);
  assign room     = MAXV - SUM_W'(acc);
  assign over     = sum > MAXV;
  assign take_len = over ? room[15:0] : desc_len;

  always_ff @(posedge clk) begin
    if (!rst_n || clear || frame_end) acc <= '0;
    else if (load)                    acc <= acc + take_len[ACC_W-1:0];
  end

  a_r9_acc_cap: assert property (@(posedge clk) disable iff (!rst_n)
    SUM_W'(acc) <= MAXV);
endmodule

// File: rtl/txr_walker.sv
module txr_walker import txr_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int MAX_DESC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic [ADDR_W-1:0] cur_ptr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic [15:0]       take_len,
  input  logic              take_over,
  input  logic              tx_tready,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              tx_tvalid,
  output logic [7:0]        tx_tdata,
  output logic              tx_tlast,
  output logic              ptr_step,
  output logic              ptr_wrap,
  output logic              len_clear,
  output logic              len_load,
  output logic [15:0]       desc_len,
  output logic              frame_end,
  output logic              ev_txbuf,
  output logic              ev_txframe,
  output logic              ev_babble
);
  localparam int DCNT_W = $clog2(MAX_DESC + 1);

  walk_state_t       state;
  desc_head_t        head;
  logic [ADDR_W-1:0] bptr;
  logic [15:0]       rem;
  logic [DCNT_W-1:0] dcount;
  logic [7:0]        obyte;
  logic              olast, head_last, last_slot;

  assign head_last = head.flags[FLAG_LAST];
  assign last_slot = (dcount + 1'b1) == DCNT_W'(MAX_DESC);
  assign busy      = (state != S_IDLE);
  assign mem_req   = (state == S_HEAD) || (state == S_PTR) ||
                     (state == S_FETCH) || (state == S_WBACK);
  assign mem_we    = (state == S_WBACK);
  assign mem_wdata = {head.flags & ~READY_MASK, head.len};
  assign tx_tvalid = (state == S_SEND);
  assign tx_tdata  = obyte;
  assign tx_tlast  = olast;
  assign len_clear = (state == S_IDLE) && kick && enable;
  assign len_load  = (state == S_PTR) && mem_ack;
  assign desc_len  = head.len;
  assign ptr_step  = (state == S_WBACK) && mem_ack;
  assign ptr_wrap  = head.flags[FLAG_WRAP];
  assign frame_end = ptr_step && head_last;

  always_comb begin
    case (state)
      S_PTR:   mem_addr = cur_ptr + ADDR_W'(4);
      S_FETCH: mem_addr = {bptr[ADDR_W-1:2], 2'b00};
      default: mem_addr = cur_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      head       <= '0;
      bptr       <= '0;
      rem        <= '0;
      dcount     <= '0;
      obyte      <= '0;
      olast      <= 1'b0;
      ev_txbuf   <= 1'b0;
      ev_txframe <= 1'b0;
      ev_babble  <= 1'b0;
    end else begin
      ev_txbuf   <= ptr_step;
      ev_txframe <= frame_end;
      ev_babble  <= len_load && take_over;
      case (state)
        S_IDLE: if (kick && enable) begin
          state  <= S_HEAD;
          dcount <= '0;
        end
        S_HEAD: if (mem_ack) begin
          head  <= mem_rdata;
          state <= mem_rdata[16 + FLAG_READY] ? S_PTR : S_IDLE;
        end
        S_PTR: if (mem_ack) begin
          bptr  <= mem_rdata[ADDR_W-1:0];
          rem   <= take_len;
          state <= (take_len == 16'd0) ? S_WBACK : S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          obyte <= mem_rdata[{bptr[1:0], 3'b000} +: 8];
          olast <= head_last && (rem == 16'd1);
          state <= S_SEND;
        end
        S_SEND: if (tx_tready) begin
          bptr  <= bptr + ADDR_W'(1);
          rem   <= rem - 16'd1;
          state <= (rem == 16'd1) ? S_WBACK : S_FETCH;
        end
        S_WBACK: if (mem_ack) begin
          dcount <= dcount + 1'b1;
          state  <= last_slot ? S_IDLE : S_HEAD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tvalid && !tx_tready) |=> (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast)));
  a_r6_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid |-> !mem_req);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !tx_tvalid));
  a_r7_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txframe |-> ev_txbuf);
  a_r10_limit: assert property (@(posedge clk) disable iff (!rst_n)
    dcount <= DCNT_W'(MAX_DESC));
  a_r5_last_only_final: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tvalid && tx_tready && tx_tlast) |=> (state == S_WBACK));
endmodule

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int ADDR_W     = 32,
  parameter int MAX_FRAME  = 2048,
  parameter int MAX_DESC   = 1024,
  parameter int ALIGN_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              kick,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_tvalid,
  input  logic              tx_tready,
  output logic [7:0]        tx_tdata,
  output logic              tx_tlast,
  output logic              ev_txbuf,
  output logic              ev_txframe,
  output logic              ev_babble
);
  logic [ADDR_W-1:0] base, cur;
  logic              step, wrap, len_clear, len_load, frame_end, over;
  logic [15:0]       desc_len, take_len;

  txr_ring_ptr #(.ADDR_W(ADDR_W), .ALIGN_LOG2(ALIGN_LOG2)) u_ptr (
    .clk(clk), .rst_n(rst_n), .enable(enable), .busy(busy),
    .base_we(base_we), .base_wdata(base_wdata), .step(step), .wrap(wrap),
    .base(base), .cur(cur)
  );

  txr_frame_len #(.MAX_FRAME(MAX_FRAME)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(len_clear), .load(len_load),
    .frame_end(frame_end), .desc_len(desc_len), .take_len(take_len), .over(over)
  );

  txr_walker #(.ADDR_W(ADDR_W), .MAX_DESC(MAX_DESC)) u_walk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick), .cur_ptr(cur),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .take_len(take_len), .take_over(over),
    .tx_tready(tx_tready), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_tvalid(tx_tvalid),
    .tx_tdata(tx_tdata), .tx_tlast(tx_tlast), .ptr_step(step), .ptr_wrap(wrap),
    .len_clear(len_clear), .len_load(len_load), .desc_len(desc_len),
    .frame_end(frame_end), .ev_txbuf(ev_txbuf), .ev_txframe(ev_txframe),
    .ev_babble(ev_babble)
  );
endmodule

// File: tb/test_txring_dma.sv
`timescale 1ns/1ps
module test_txring_dma;
  localparam int MAXF = 40;
  localparam int MAXD = 6;
  localparam int ALG  = 3;

  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, base_we = 1'b0, kick = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_tvalid, tx_tready = 1'b0, tx_tlast;
  logic [7:0]  tx_tdata;
  logic        ev_txbuf, ev_txframe, ev_babble;

  always #10 clk = ~clk;

  txring_dma #(.ADDR_W(32), .MAX_FRAME(MAXF), .MAX_DESC(MAXD), .ALIGN_LOG2(ALG)) i_txring_dma (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_we(base_we), .base_wdata(base_wdata),
    .kick(kick), .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_tvalid(tx_tvalid),
    .tx_tready(tx_tready), .tx_tdata(tx_tdata), .tx_tlast(tx_tlast), .ev_txbuf(ev_txbuf),
    .ev_txframe(ev_txframe), .ev_babble(ev_babble)
  );

  int checks = 0, errors = 0, cyc = 0, lat = 0;
  int exp_buf, exp_frm, exp_bab, obs_buf, obs_frm, obs_bab;
  bit bp_mode = 0;
  string cur_tag = "R1";
  logic [31:0] mem [int unsigned];
  logic [64:0] exp_ops [$];
  logic [8:0]  exp_bytes [$];
  int unsigned base_m = 0, cur_m = 0;

  task automatic chk(input bit ok, input string what, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int unsigned a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // memory slave: request-ack with random latency
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat = $urandom % 3;
    end else if (rst_n && mem_req) begin
      if (lat > 0) lat--;
      else begin
        if (exp_ops.size() == 0)
          chk(1'b0, {cur_tag, " R12 unexpected memory request"}, {mem_we, mem_addr, mem_wdata}, 65'h0);
        else begin
          logic [64:0] op;
          op = exp_ops.pop_front();
          chk(op[64] == mem_we && op[63:32] == mem_addr && (!mem_we || op[31:0] == mem_wdata),
              {cur_tag, " R12 memory op"}, {mem_we, mem_addr, mem_we ? mem_wdata : 32'h0}, op);
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd(mem_addr);
        mem_ack = 1'b1;
      end
    end
  end

  // stream sink with optional back-pressure
  always @(negedge clk) begin
    if (!rst_n) tx_tready = 1'b0;
    else begin
      tx_tready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
      if (tx_tvalid && tx_tready) begin
        if (exp_bytes.size() == 0)
          chk(1'b0, {cur_tag, " R4 unexpected byte"}, {56'h0, tx_tlast, tx_tdata}, 65'h0);
        else begin
          logic [8:0] e;
          e = exp_bytes.pop_front();
          chk(e == {tx_tlast, tx_tdata}, {cur_tag, " R4 R5 stream byte"}, {56'h0, tx_tlast, tx_tdata}, {56'h0, e});
        end
      end
    end
  end

  always @(negedge clk) begin
    if (ev_txbuf) obs_buf++;
    if (ev_txframe) obs_frm++;
    if (ev_babble) obs_bab++;
  end

  task automatic model_walk();
    logic [31:0] ov [int unsigned];
    int unsigned c, acc, take;
    logic [31:0] w0, p, wd, wv;
    c = cur_m; acc = 0;
    for (int n = 0; n < MAXD; n++) begin
      exp_ops.push_back({1'b0, c, 32'h0});
      w0 = ov.exists(c) ? ov[c] : rd(c);
      if (!w0[31]) break;
      exp_ops.push_back({1'b0, c + 32'd4, 32'h0});
      p = rd(c + 4);
      if (acc + w0[15:0] > MAXF) begin take = MAXF - acc; exp_bab++; end
      else take = w0[15:0];
      for (int i = 0; i < int'(take); i++) begin
        int unsigned a;
        a = p + i;
        exp_ops.push_back({1'b0, a & ~32'd3, 32'h0});
        wv = rd(a & ~32'd3) >> (8 * (a % 4));
        exp_bytes.push_back({w0[27] && (i == int'(take) - 1), wv[7:0]});
      end
      acc += take;
      wd = w0 & ~32'h8000_0000;
      exp_ops.push_back({1'b1, c, wd});
      ov[c] = wd;
      exp_buf++;
      if (w0[27]) begin exp_frm++; acc = 0; end
      c = w0[29] ? base_m : c + 8;
    end
    cur_m = c;
  endtask

  task automatic set_desc(input int unsigned a, input logic [15:0] fl, input logic [15:0] len, input logic [31:0] p);
    mem[a] = {fl, len};
    mem[a + 4] = p;
  endtask

  task automatic run_walk(input string tag, input bit second_kick);
    cur_tag = tag;
    exp_buf = 0; exp_frm = 0; exp_bab = 0; obs_buf = 0; obs_frm = 0; obs_bab = 0;
    model_walk();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    chk(busy == 1'b1, {tag, " R13 busy after kick"}, {64'h0, busy}, 65'h1);
    if (second_kick) begin
      repeat (3) @(negedge clk);
      kick = 1'b1;
      @(negedge clk) kick = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_ops.size() == 0, {tag, " R3 R10 all memory ops issued"}, 65'(exp_ops.size()), 65'h0);
    chk(exp_bytes.size() == 0, {tag, " R4 all bytes streamed"}, 65'(exp_bytes.size()), 65'h0);
    chk(obs_buf == exp_buf, {tag, " R7 buffer events"}, 65'(obs_buf), 65'(exp_buf));
    chk(obs_frm == exp_frm, {tag, " R7 frame events"}, 65'(obs_frm), 65'(exp_frm));
    chk(obs_bab == exp_bab, {tag, " R9 babble events"}, 65'(obs_bab), 65'(exp_bab));
    chk(busy == 1'b0, {tag, " R13 busy low after walk"}, {64'h0, busy}, 65'h0);
    exp_ops.delete();
    exp_bytes.delete();
  endtask

  initial begin
    for (int w = 0; w < 2048; w++) mem[32'h1000 + 4 * w] = (32'h1000 + 4 * w) * 32'h9E37_79B1 + w;
    repeat (5) @(negedge clk);
    chk(!busy && !mem_req && !tx_tvalid && !ev_txbuf && !ev_txframe && !ev_babble,
        "R1 reset state", {59'h0, busy, mem_req, tx_tvalid, ev_txbuf, ev_txframe, ev_babble}, 65'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !tx_tvalid, "R1 state after release", {62'h0, busy, mem_req, tx_tvalid}, 65'h0);

    // R11: odd base value gets aligned to 8 bytes
    base_wdata = 32'h0000_0105; base_we = 1'b1;
    @(negedge clk) base_we = 1'b0;
    base_m = 32'h100; cur_m = 32'h100;

    // R2: kick while disabled is ignored
    cur_tag = "R2";
    set_desc(32'h100, 16'h8800, 16'd5, 32'h1003);
    kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R2 kick while disabled", {64'h0, busy}, 65'h0);
    chk(mem[32'h100][31] == 1'b1, "R2 descriptor untouched", {64'h0, mem[32'h100][31]}, 65'h1);

    enable = 1'b1;
    @(negedge clk);
    // T1: single descriptor frame from unaligned buffer, then stop
    set_desc(32'h108, 16'h0000, 16'd0, 32'h0);
    run_walk("R3 R4 R5 R7 R11", 1'b0);

    // T2: multi-descriptor frames with back-pressure, zero length, wrap
    bp_mode = 1;
    set_desc(32'h108, 16'h8000, 16'd3, 32'h1101);
    set_desc(32'h110, 16'h8000, 16'd0, 32'h1200);
    set_desc(32'h118, 16'h8800, 16'd4, 32'h1302);
    set_desc(32'h120, 16'hA800, 16'd2, 32'h1403);
    run_walk("R6 R8 R2", 1'b1);

    // T3: reload from base while disabled; truncation cases
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    cur_m = base_m;
    set_desc(32'h100, 16'h8000, 16'd30, 32'h1500);
    set_desc(32'h108, 16'h8800, 16'd20, 32'h1600);
    set_desc(32'h110, 16'h8800, 16'd6, 32'h1681);
    set_desc(32'h118, 16'h8000, 16'd50, 32'h1702);
    set_desc(32'h120, 16'h8800, 16'd3, 32'h1800);
    set_desc(32'h128, 16'h0000, 16'd0, 32'h0);
    run_walk("R9 R11", 1'b0);

    // T4: runaway guard over an eight-slot ring
    bp_mode = 0;
    enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    cur_m = base_m;
    for (int k = 0; k < 8; k++)
      set_desc(32'h100 + 8 * k, (k == 7) ? 16'hA800 : 16'h8800, 16'd1, 32'h1900 + k);
    run_walk("R10", 1'b0);
    chk(mem[32'h130][31] == 1'b1, "R10 seventh descriptor still ready", {64'h0, mem[32'h130][31]}, 65'h1);
    run_walk("R10 R8 second activation", 1'b0);
    chk(mem[32'h138][31] == 1'b0, "R7 wrap descriptor released", {64'h0, mem[32'h138][31]}, 65'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule